// File: doc/BRIEF.md
# Power Fault Shutdown Sequencer

This block watches a supply-good comparator and steers a disk drive's power stage between three regimes: a power-on hold, normal running, and an ordered shutdown after a supply fault. While power comes up, the active-low power-on-reset output stays asserted. It is released only after the filtered supply-good signal has stayed true for a programmed number of system clock cycles. Any drop in the filtered supply during the hold restarts the count.

When the filtered supply fails during normal running, the sequencer performs four steps in a fixed order. First it resets the registers. Then it places the spindle power stage in tristate. Then it retracts the head actuator. Finally, after a programmed delay, it applies the spindle dynamic brake. Each step is added on top of the ones before it, and each earlier step stays asserted. The shutdown always runs to the end, even if the supply recovers partway through. After braking, the block waits for a good supply and then re-enters the power-on hold.

The step lengths come from three input words, each counted in system clock cycles. The supply-good input is first synchronized to the system clock. It is then accepted only when it has held the same level for four consecutive samples.

Top module: `pwr_fault_seq`

## Requirements
- R1: While reset is asserted, and until the first transition after it, the outputs are: por_n_o=0, reg_rst_o=1, spin_tri_o=1, retract_o=0, brake_o=0.
- R2: supply_ok_i passes through a 2-flop synchronizer. The filtered supply level changes only when 4 consecutive synchronized samples agree, so a pulse lasting 3 or fewer cycles has no effect on any output.
- R3: In the power-on hold, por_n_o rises after the filtered supply has stayed good for por_hold_cyc_i cycles (a value of 0 counts as 1). A filtered drop restarts the count. por_n_o is high only in normal running.
- R4: A filtered supply drop during running starts the shutdown. Step 1 (reg_rst_o=1 with spin_tri_o=0) lasts step_cyc_i cycles (0 counts as 1).
- R5: Step 2 adds spin_tri_o=1 and lasts step_cyc_i cycles.
- R6: Step 3 adds retract_o=1. It ends after step_cyc_i cycles, or after its first cycle in which retract_done_i is high, whichever comes first.
- R7: After step 3, a delay of brake_dly_cyc_i cycles passes (0 counts as 1) with retraction held. Then brake_o=1 is set and stays set until the filtered supply is good, at which point the block returns to the power-on hold.
- R8: Once started, the shutdown sequence reaches the brake step even if the supply recovers in the middle of it.
- R9: brake_o is never 1 while spin_tri_o is 0; that is, the brake and spindle drive are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| supply_ok_i | input | 1 | Raw supply-good comparator output |
| retract_done_i | input | 1 | Retraction-complete indication; ends step 3 early |
| por_hold_cyc_i | input | CNT_W | Power-on hold length in cycles |
| step_cyc_i | input | CNT_W | Length of shutdown steps 1 to 3 in cycles |
| brake_dly_cyc_i | input | CNT_W | Delay before the brake is applied, in cycles |
| reg_rst_o | output | 1 | Register reset request |
| spin_tri_o | output | 1 | Spindle power stage tristate (1 = drive disabled) |
| retract_o | output | 1 | Actuator retract enable |
| brake_o | output | 1 | Spindle dynamic brake enable |
| por_n_o | output | 1 | Power-on reset, active low |

## Verification
The bench targets several corner cases, each of which exposes a specific design fault:
- Short supply glitches, both high and low, during the power-on hold. A filter with too short a window would release reset or restart the hold count.
- Recovery of the supply in the middle of the shutdown. A sequencer that aborted would jump back to the hold and never brake.
- An early retract-complete indication. A block that ignored it would keep retracting for the full step time and delay the brake.
- Zero-length programmed times. An off-by-one in the step counter would collapse a step or wrap to a huge count.

A behavioural reference model tracks every output on every cycle, so any misordered step or wrong step length shows up as a mismatch at the cycle where it first occurs.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_POR     = 3'd0,
    ST_RUN     = 3'd1,
    ST_REGRST  = 3'd2,
    ST_TRI     = 3'd3,
    ST_RETRACT = 3'd4,
    ST_BRKDLY  = 3'd5,
    ST_BRAKE   = 3'd6
  } pfs_state_e;
endpackage

// File: rtl/pfs_reset_sync.sv
module pfs_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/pfs_sync_filter.sv
module pfs_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  localparam int HW = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;
  logic                   level_q, level_d;
  logic [FILT_LEN-1:0]    window;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= raw_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign window = {hist_q, sync_q[SYNC_STAGES-1]};

  always_comb begin
    level_d = level_q;
    if (&window)       level_d = 1'b1;
    else if (~|window) level_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      hist_q  <= window[HW-1:0];
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  // a filtered level change must follow a stable synchronized sample
  AST_FILT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> level_q == $past(sync_q[SYNC_STAGES-1])); // R2
endmodule

// File: rtl/pfs_step_timer.sv
module pfs_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i || (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
  import pfs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             retract_done_i,
  input  logic [CNT_W-1:0] por_hold_cyc_i,
  input  logic [CNT_W-1:0] step_cyc_i,
  input  logic [CNT_W-1:0] brake_dly_cyc_i,
  output logic             reg_rst_o,
  output logic             spin_tri_o,
  output logic             retract_o,
  output logic             brake_o,
  output logic             por_n_o
);
  logic             rst_n;
  logic             good;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  pfs_state_e       state_q, state_d;

  function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - CNT_W'(1);
  endfunction

  pfs_reset_sync i_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  pfs_sync_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) i_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .raw_i   (supply_ok_i),
    .level_o (good)
  );

  pfs_step_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:     if (good && cnt >= last_idx(por_hold_cyc_i)) state_d = ST_RUN;
      ST_RUN:     if (!good) state_d = ST_REGRST;
      ST_REGRST:  if (cnt >= last_idx(step_cyc_i)) state_d = ST_TRI;
      ST_TRI:     if (cnt >= last_idx(step_cyc_i)) state_d = ST_RETRACT;
      ST_RETRACT: if (retract_done_i || cnt >= last_idx(step_cyc_i)) state_d = ST_BRKDLY;
      ST_BRKDLY:  if (cnt >= last_idx(brake_dly_cyc_i)) state_d = ST_BRAKE;
      ST_BRAKE:   if (good) state_d = ST_POR;
      default:    state_d = ST_POR;
    endcase
  end

  assign cnt_clr = (state_d != state_q) || (state_q == ST_POR && !good);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= ST_POR;
    else        state_q <= state_d;
  end

  assign por_n_o    = (state_q == ST_RUN);
  assign reg_rst_o  = (state_q != ST_RUN);
  assign spin_tri_o = (state_q == ST_POR) || (state_q == ST_TRI) ||
                      (state_q == ST_RETRACT) || (state_q == ST_BRKDLY) ||
                      (state_q == ST_BRAKE);
  assign retract_o  = (state_q == ST_RETRACT) || (state_q == ST_BRKDLY) ||
                      (state_q == ST_BRAKE);
  assign brake_o    = (state_q == ST_BRAKE);

  AST_BRAKE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n)
    brake_o |-> spin_tri_o); // R9
  AST_FAULT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_RUN && !good) |=> (reg_rst_o && !spin_tri_o)); // R4
  AST_RETRACT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(retract_o) |-> ($past(spin_tri_o) && reg_rst_o)); // R6
  AST_BRAKE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(brake_o) |-> ($past(retract_o) && retract_o)); // R7
  AST_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q inside {ST_REGRST, ST_TRI, ST_RETRACT, ST_BRKDLY}) |=>
    (state_q inside {ST_REGRST, ST_TRI, ST_RETRACT, ST_BRKDLY, ST_BRAKE})); // R8
  AST_POR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(por_n_o) |-> ($past(state_q) == ST_POR && $past(good))); // R3
endmodule

// File: tb/test_pwr_fault_seq.sv
module test_pwr_fault_seq;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic retd = 1'b0;
  logic [CW-1:0] por_cyc = 16'd6;
  logic [CW-1:0] stp_cyc = 16'd3;
  logic [CW-1:0] brk_cyc = 16'd5;
  logic reg_rst, spin_tri, retract, brake, por_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_run = 3, m_rcnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_last = 0, m_good = 0;

  always #10 clk = ~clk;

  pwr_fault_seq #(.CNT_W(CW)) i_pwr_fault_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .retract_done_i(retd),
    .por_hold_cyc_i(por_cyc), .step_cyc_i(stp_cyc), .brake_dly_cyc_i(brk_cyc),
    .reg_rst_o(reg_rst), .spin_tri_o(spin_tri), .retract_o(retract),
    .brake_o(brake), .por_n_o(por_n)
  );

  function automatic int lim(input logic [CW-1:0] n);
    return (n == 0) ? 0 : int'(n) - 1;
  endfunction

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_run = 3; m_s1 = 0; m_s2 = 0; m_last = 0; m_good = 0;
  endtask

  always @(posedge clk) begin
    int ns;
    if (!rst_n) begin
      m_rcnt = 0; m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; m_reset();
    end else begin
      ns = m_st;
      case (m_st)
        0: if (m_good && m_cnt >= lim(por_cyc)) ns = 1;
        1: if (!m_good) ns = 2;
        2: if (m_cnt >= lim(stp_cyc)) ns = 3;
        3: if (m_cnt >= lim(stp_cyc)) ns = 4;
        4: if (retd || m_cnt >= lim(stp_cyc)) ns = 5;
        5: if (m_cnt >= lim(brk_cyc)) ns = 6;
        default: if (m_good) ns = 0;
      endcase
      if (ns != m_st || (m_st == 0 && !m_good)) m_cnt = 0;
      else if (m_cnt < 65535) m_cnt++;
      if (m_s2 == m_last) m_run++;
      else begin m_run = 1; m_last = m_s2; end
      if (m_run >= 4) m_good = m_last;
      m_s2 = m_s1; m_s1 = supply_ok;
      m_st = ns;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      chk("R3 por_n", por_n, m_st == 1);
      chk("R4 reg_rst", reg_rst, m_st != 1);
      chk("R5 spin_tri", spin_tri, m_st == 0 || m_st >= 3);
      chk("R6 retract", retract, m_st >= 4);
      chk("R7 brake", brake, m_st == 6);
      chk("R9 brake_excl", brake && !spin_tri, 1'b0);
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_on(input int which);
    int n = 0;
    while (n < 500 && !((which == 0 && reg_rst && !por_n) || (which == 1 && spin_tri) ||
                        (which == 2 && retract) || (which == 3 && brake) ||
                        (which == 4 && por_n))) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int t;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    cmp_en = 1'b1;
    // R1 reset state
    chk("R1 por_n", por_n, 1'b0);
    chk("R1 reg_rst", reg_rst, 1'b1);
    chk("R1 spin_tri", spin_tri, 1'b1);
    chk("R1 retract", retract, 1'b0);
    chk("R1 brake", brake, 1'b0);
    // R2 short high glitch ignored
    supply_ok = 1'b1; cyc(3); supply_ok = 1'b0; cyc(20);
    chk("R2 glitch_high", por_n, 1'b0);
    // R3 power-up with a short low glitch during hold
    supply_ok = 1'b1; cyc(8); supply_ok = 1'b0; cyc(2); supply_ok = 1'b1; cyc(30);
    chk("R3 released", por_n, 1'b1);
    // R2 short low glitch in run ignored
    supply_ok = 1'b0; cyc(3); supply_ok = 1'b1; cyc(15);
    chk("R2 glitch_low", por_n, 1'b1);
    // R4..R7 full ordered shutdown
    supply_ok = 1'b0;
    wait_on(0); chk("R4 tri_not_yet", spin_tri, 1'b0);
    wait_on(1); chk("R5 keeps_reset", reg_rst, 1'b1); chk("R5 no_retract", retract, 1'b0);
    wait_on(2); chk("R6 no_brake", brake, 1'b0);
    wait_on(3); chk("R7 retract_held", retract, 1'b1);
    cyc(10); chk("R7 brake_stays", brake, 1'b1);
    // recover, then R8: recovery mid-sequence does not abort
    supply_ok = 1'b1; wait_on(4);
    supply_ok = 1'b0; wait_on(1);
    supply_ok = 1'b1;
    wait_on(3); chk("R8 brake_reached", brake, 1'b1);
    wait_on(4); chk("R8 back_running", por_n, 1'b1);
    // R6 early retract-complete with long steps
    stp_cyc = 16'd20; retd = 1'b1;
    supply_ok = 1'b0; wait_on(2);
    t = 0;
    while (!brake && t < 200) begin @(negedge clk); t++; end
    chk("R6 early_done", t == int'(brk_cyc) + 1, 1'b1);
    retd = 1'b0;
    // zero-length programmed times
    por_cyc = 16'd0; stp_cyc = 16'd0; brk_cyc = 16'd0;
    supply_ok = 1'b1; wait_on(4);
    chk("R3 zero_hold", por_n, 1'b1);
    supply_ok = 1'b0; wait_on(3);
    chk("R7 zero_delay", brake, 1'b1);
    cyc(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule